// File: doc/BRIEF.md
# Field-Programmable Sum-of-Products Array

This block is a programmable logic array. The AND plane and the OR plane can both be set at run time. Each of `N_IN` inputs is offered in true and in complemented form to each of `N_PROD` product terms. Each of `N_OUT` OR gates can pick any subset of those products. Each OR result then passes through an exclusive-OR stage whose second leg can be tied high or tied low. A product that two outputs both select is built only once and feeds both of them.

The configuration arrives one bit per clock on a serial port and collects in a staging register. A rising edge on the commit strobe copies the staging register into the live configuration. A half-written pattern therefore never reaches the logic. The path from `dataIn` to `dataOut` has no register in it. After reset the live configuration is all zeros, so every output is 0.

Top module: `pla_core`

## Requirements
- R1: Product term p ANDs every connected literal. Configuration bit p*2*N_IN+2*i connects the true form of input i, and bit p*2*N_IN+2*i+1 connects its complement.
- R2: A product term with no literal connected evaluates to 1. A product term that connects both the true and the complemented literal of the same input evaluates to 0.
- R3: Output o ORs the products selected by bits 2*N_IN*N_PROD+o*N_PROD+p. One product may serve several outputs. An output with no product selected gives 0 before its polarity stage.
- R4: Each output has a two-bit polarity field at offset 2*N_IN*N_PROD+N_PROD*N_OUT+2*o: bit +1 ties the XOR leg high and bit +0 ties it low. The output is complemented only when the high tie alone is set. When both ties are set, the low tie wins.
- R5: The configuration is 2*N_IN*N_PROD + N_PROD*N_OUT + 2*N_OUT bits long. It shifts in most significant bit first, one bit per clock while `cfgEn` is high. The staging register holds its value while `cfgEn` is low, and a bit shifted in beyond the full length pushes the oldest bit out.
- R6: Shifting has no effect on `dataOut` until a commit. The live configuration changes only on a commit.
- R7: A commit happens on the clock edge where `cfgLoad` is high and was low on the edge before. A strobe held high commits only once. The outputs show the new configuration after that edge.
- R8: An active-low asynchronous `rstN` clears both the staging and the live configuration. Every output is then 0 for any input.
- R9: `dataOut` follows a change of `dataIn` within the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEn | input | 1 | Shift enable for the staging register |
| cfgBit | input | 1 | Serial configuration bit, MSB first |
| cfgLoad | input | 1 | Commit strobe, acts on its rising edge |
| dataIn | input | N_IN | Logic inputs |
| dataOut | output | N_OUT | Logic outputs |

## Verification
The hold properties assume that the only way to move the staging register is `cfgEn` and the only way to move the live configuration is a rising edge of `cfgLoad`. The combinational checks assume that `dataIn` carries known levels. The stimulus changes `cfgEn`, `cfgBit`, `cfgLoad` and `dataIn` only on the falling clock edge and always drives 0 or 1, never X. A reference model tracks the staging bits as a queue and is compared with the outputs after every rising edge. This covers commits made while shifting is still going on and strobes that stay high across many cycles.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // strobes passed from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } cfgStrobe_t;
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEn,
  input  logic       cfgLoad,
  output cfgStrobe_t strobe
);
  logic loadPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadPrev <= 1'b0;
    else       loadPrev <= cfgLoad;
  end

  always_comb begin
    strobe.shiftEn = cfgEn;
    strobe.loadEn  = cfgLoad & ~loadPrev;
  end

  // a held commit strobe must not produce two commits in a row
  assert_single_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> !strobe.loadEn);
endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_PROD = 4,
  parameter int N_OUT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic              cfgBit,
  input  logic [N_IN-1:0]   dataIn,
  output logic [N_OUT-1:0]  dataOut
);
  localparam int AND_W   = 2 * N_IN * N_PROD;
  localparam int OR_BASE = AND_W;
  localparam int OR_W    = N_PROD * N_OUT;
  localparam int POL_BASE = OR_BASE + OR_W;
  localparam int CFG_W   = POL_BASE + 2 * N_OUT;

  logic [CFG_W-1:0] shadow;
  logic [CFG_W-1:0] active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadow <= '0;
    else if (strobe.shiftEn) shadow <= {shadow[CFG_W-2:0], cfgBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= '0;
    else if (strobe.loadEn) active <= shadow;
  end

  // AND plane
  logic [N_PROD-1:0][N_IN-1:0] litOk;
  logic [N_PROD-1:0]           prodTerm;

  for (genvar p = 0; p < N_PROD; p++) begin : g_prod
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      logic useTrue, useComp;
      assign useTrue = active[p*2*N_IN + 2*i];
      assign useComp = active[p*2*N_IN + 2*i + 1];
      assign litOk[p][i] = (~useTrue | dataIn[i]) & (~useComp | ~dataIn[i]);
    end
    assign prodTerm[p] = &litOk[p];
  end

  // OR plane and polarity stage
  logic [N_OUT-1:0] orSum;
  logic [N_OUT-1:0] invert;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic tieHi, tieLo;
    assign orSum[o]   = |(prodTerm & active[OR_BASE + o*N_PROD +: N_PROD]);
    assign tieHi      = active[POL_BASE + 2*o + 1];
    assign tieLo      = active[POL_BASE + 2*o];
    assign invert[o]  = tieHi & ~tieLo;
    assign dataOut[o] = orSum[o] ^ invert[o];
  end

  // staging register moves only when shifting
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shadow));

  // live configuration moves only on a commit
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(active));

  always_comb begin
    // contradictory literals kill the product
    for (int p = 0; p < N_PROD; p++) begin
      for (int i = 0; i < N_IN; i++) begin
        if (active[p*2*N_IN + 2*i] && active[p*2*N_IN + 2*i + 1])
          assert_contradict_R2: assert (!prodTerm[p])
            else $error("product %0d live with contradictory literals", p);
      end
    end
    // an output with nothing selected and no inversion is low
    for (int o = 0; o < N_OUT; o++) begin
      if (active[OR_BASE + o*N_PROD +: N_PROD] == '0 && !invert[o])
        assert_empty_or_R3: assert (!dataOut[o])
          else $error("output %0d high with empty OR", o);
    end
    // cleared configuration drives every output low
    if (active == '0)
      assert_zero_cfg_R8: assert (dataOut == '0)
        else $error("outputs active with cleared configuration");
  end
endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_PROD = 4,
  parameter int N_OUT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEn,
  input  logic             cfgBit,
  input  logic             cfgLoad,
  input  logic [N_IN-1:0]  dataIn,
  output logic [N_OUT-1:0] dataOut
);
  cfgStrobe_t strobe;

  pla_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgEn   (cfgEn),
    .cfgLoad (cfgLoad),
    .strobe  (strobe)
  );

  pla_datapath #(
    .N_IN   (N_IN),
    .N_PROD (N_PROD),
    .N_OUT  (N_OUT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgBit  (cfgBit),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/test_pla_core.sv
`timescale 1ns/1ps
module test_pla_core;
  localparam int N = 3, P = 4, M = 2;
  localparam int ORB = 2*N*P, POLB = ORB + P*M, TOT = POLB + 2*M;

  logic clk = 0, rstN = 0, cfgEn = 0, cfgBit = 0, cfgLoad = 0;
  logic [N-1:0] dataIn = '0;
  logic [M-1:0] dataOut;
  int runCnt = 0, failCnt = 0;
  logic [TOT-1:0] cfgVec;

  always #2 clk = ~clk;

  pla_core #(.N_IN(N), .N_PROD(P), .N_OUT(M)) i_pla_core (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .cfgLoad(cfgLoad), .dataIn(dataIn), .dataOut(dataOut));

  // behavioural model: staging bits as a queue, index 0 = newest
  bit shq[$];
  bit mAct[TOT];
  bit mPrevLoad;

  function automatic logic [M-1:0] modelOut(logic [N-1:0] x);
    logic [M-1:0] r;
    for (int o = 0; o < M; o++) begin
      bit acc = 0;
      for (int p = 0; p < P; p++) begin
        if (mAct[ORB + o*P + p]) begin
          bit term = 1;
          for (int i = 0; i < N; i++) begin
            if (mAct[p*2*N + 2*i] && !x[i]) term = 0;
            if (mAct[p*2*N + 2*i + 1] && x[i]) term = 0;
          end
          acc = acc | term;
        end
      end
      if (mAct[POLB + 2*o + 1] && !mAct[POLB + 2*o]) acc = !acc;
      r[o] = acc;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [M-1:0] act, logic [M-1:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      shq.delete();
      for (int k = 0; k < TOT; k++) begin shq.push_back(0); mAct[k] = 0; end
      mPrevLoad = 0;
    end else begin
      if (cfgLoad && !mPrevLoad)
        for (int k = 0; k < TOT; k++) mAct[k] = shq[k];
      if (cfgEn) begin shq.push_front(cfgBit); void'(shq.pop_back()); end
      mPrevLoad = cfgLoad;
    end
    #1;
    if (rstN) check("R6 R7 per-cycle model", dataOut, modelOut(dataIn));
  end

  // independent expectations
  function automatic logic [M-1:0] expA(logic [N-1:0] x);
    logic f0, f1;
    f0 = (x[0] & x[1]) | (x[0] & ~x[2]) | (~x[0] & x[1] & ~x[2]);
    f1 = ~((x[0] & x[1]) | (x[1] & x[2]));
    return {f1, f0};
  endfunction

  function automatic logic [M-1:0] expB(logic [N-1:0] x);
    return {x[1], 1'b1};
  endfunction

  task automatic setLit(int p, int i, int comp); cfgVec[p*2*N + 2*i + comp] = 1'b1; endtask
  task automatic setOr(int o, int p);            cfgVec[ORB + o*P + p] = 1'b1; endtask
  task automatic setPol(int o, int hi);          cfgVec[POLB + 2*o + hi] = 1'b1; endtask

  task automatic shiftCfg();
    for (int k = TOT-1; k >= 0; k--) begin
      @(negedge clk); cfgEn = 1; cfgBit = cfgVec[k];
    end
    @(negedge clk); cfgEn = 0; cfgBit = 0;
  endtask

  task automatic pulseLoad();
    @(negedge clk); cfgLoad = 1;
    @(negedge clk); cfgLoad = 0;
  endtask

  // drives each input pattern between edges and samples before any clock
  task automatic sweep(string tag, int which);
    for (int v = 0; v < (1 << N); v++) begin
      @(negedge clk); dataIn = v[N-1:0];
      #1;
      case (which)
        0: check(tag, dataOut, '0);
        1: check(tag, dataOut, expA(dataIn));
        2: check(tag, dataOut, expB(dataIn));
        default: check(tag, dataOut, 2'b11);
      endcase
    end
  endtask

  initial begin
    #800000;
    runCnt++; failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    sweep("R8 reset outputs low", 0);

    // config A: P0=x0x1 P1=x0~x2 P2=~x0x1~x2 P3=x1x2; out0=P0|P1|P2, out1=~(P0|P3)
    cfgVec = '0;
    setLit(0,0,0); setLit(0,1,0);
    setLit(1,0,0); setLit(1,2,1);
    setLit(2,0,1); setLit(2,1,0); setLit(2,2,1);
    setLit(3,1,0); setLit(3,2,0);
    setOr(0,0); setOr(0,1); setOr(0,2);
    setOr(1,0); setOr(1,3);
    setPol(1,1);
    shiftCfg();
    sweep("R6 shifted but not committed", 0);
    pulseLoad();
    sweep("R1 R3 R4 R9 config A truth table", 1);

    // config B: P0 empty, P1 contradictory, P2=x1; out0={P0} both ties, out1={P1,P2} low tie
    cfgVec = '0;
    setLit(1,0,0); setLit(1,0,1);
    setLit(2,1,0);
    setOr(0,0); setOr(1,1); setOr(1,2);
    setPol(0,1); setPol(0,0); setPol(1,0);
    @(negedge clk); cfgLoad = 1;
    shiftCfg();
    sweep("R7 held strobe commits once", 1);
    @(negedge clk); cfgLoad = 0;
    sweep("R7 strobe released", 1);
    pulseLoad();
    sweep("R2 R4 config B", 2);

    // config C: nothing selected, both outputs tied high
    cfgVec = '0;
    setPol(0,1); setPol(1,1);
    shiftCfg();
    pulseLoad();
    sweep("R3 R4 empty OR inverted", 3);

    // asynchronous reset between edges
    @(negedge clk); #0.5 rstN = 0; #0.5;
    check("R8 async clear", dataOut, '0);
    @(negedge clk); rstN = 1;

    // one extra leading bit falls off the far end
    @(negedge clk); cfgEn = 1; cfgBit = 1;
    shiftCfg();
    @(negedge clk); cfgEn = 0;
    repeat (2) @(negedge clk);
    sweep("R5 not committed yet", 0);
    pulseLoad();
    sweep("R5 length and MSB-first order", 3);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule